// File: doc/BRIEF.md
# CPU Interrupt Acceptance Sequencer

This block is the interrupt front end of an 8-bit CPU core. It holds the two interrupt enable flags and the maskable-mode register. At each instruction boundary it chooses between a latched non-maskable request and a level-sensitive maskable request. After accepting one, it steps through a short fixed sequence of strobes that the rest of the core carries out: an acknowledge cycle, a request to push the program counter, and then either a new program counter value or an opcode to inject.

The non-maskable path always ends at a fixed entry address. The maskable path has three modes:
- Mode 0 injects the byte the device places on the data bus.
- Mode 1 jumps to a fixed entry address.
- Mode 2 fetches a 16-bit entry address from a table in memory. The table is addressed by the I register as the high byte and an even device vector as the low byte. The two bytes are read over a small valid/ready read channel.

The read channel has these rules. `rd_valid` and `rd_addr` stay unchanged until the cycle in which `rd_ready` is high. That cycle is the handshake. The memory may hold `rd_ready` low for any number of cycles. The read response has no back-pressure. The block waits for `rsp_valid` in any cycle after the handshake and takes `rsp_data` in that cycle. All other pins are plain one-cycle strobes or levels.

Top module: `irq_seq`

## Requirements
- R1: Reset clears both enable flags and selects maskable mode 0. While reset is held, every output strobe is low and `busy` is low.
- R2: An EI event sets both enable flags and a DI event clears both. If both come in one cycle, DI wins. A low `int_n` is ignored while the first flag is 0.
- R3: A request is taken only on an `instr_done` strobe while `busy` is low. The strobe must not carry `ev_ei` or `ev_di`, so the earliest acceptance after EI or DI is at the end of the next instruction.
- R4: A falling edge on `nmi_n` is latched and held until it is taken. It beats a maskable request and is taken whatever the flags hold. It produces `push_pc`, then `pc_load` with `pc_new` = 0x0066. It clears the first flag, leaves the second unchanged, and does not fire again while the line stays low.
- R5: An RETN event copies the second enable flag into the first.
- R6: Taking a maskable request clears both flags and raises `iack` for exactly one cycle. `dbus` and `i_reg` are captured in that cycle.
- R7: In mode 0 no push is requested. In the cycle after `iack`, `inj_valid` is high and `inj_op` holds the captured byte.
- R8: In mode 1 the block produces `push_pc`, then `pc_load` with `pc_new` = 0x0038.
- R9: In mode 2 the block produces `push_pc`. It then reads address {I, vector with bit 0 forced to 0} for the low byte and {I, vector with bit 0 forced to 1} for the high byte. It ends with `pc_load`, where `pc_new` = {high, low}.
- R10: While `rd_valid` is high and `rd_ready` is low, `rd_valid` stays high and `rd_addr` stays stable.
- R11: `ev_im` loads the mode from `im_sel`: 0 gives mode 0, 1 gives mode 1, 2 gives mode 2. The value 3 leaves the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| int_n | input | 1 | Maskable request, level, active low |
| nmi_n | input | 1 | Non-maskable request, falling edge |
| instr_done | input | 1 | Instruction boundary strobe |
| ev_ei | input | 1 | Decoded EI, same cycle as its boundary |
| ev_di | input | 1 | Decoded DI, same cycle as its boundary |
| ev_retn | input | 1 | Decoded RETN |
| ev_im | input | 1 | Decoded mode-set instruction |
| im_sel | input | 2 | Mode carried by `ev_im` |
| i_reg | input | 8 | Current I register |
| dbus | input | 8 | Data bus during acknowledge |
| iack | output | 1 | Acknowledge strobe (M1 with IORQ) |
| push_pc | output | 1 | Push current PC |
| pc_load | output | 1 | Load `pc_new` into PC |
| pc_new | output | 16 | Service entry address |
| inj_valid | output | 1 | Execute `inj_op` as next instruction |
| inj_op | output | 8 | Opcode to inject (mode 0) |
| rd_valid | output | 1 | Table read request valid |
| rd_ready | input | 1 | Table read request accepted |
| rd_addr | output | 16 | Table read address |
| rsp_valid | input | 1 | Table read data valid |
| rsp_data | input | 8 | Table read data |
| busy | output | 1 | A service sequence is in progress |

## Verification
The bench targets several corner cases. For each one, a wrong design shows a specific symptom:
- A boundary that carries EI while `int_n` is already low. A design without the one-instruction shadow acknowledges too early.
- An odd vector in mode 2. A design that fails to force bit 0 reads the wrong table entries and jumps to the wrong address.
- An NMI and an INT pending together. A design with the wrong priority acknowledges the INT first.
- An INT left waiting while an NMI is serviced, then released by RETN. A design that clears or ignores the second flag never takes the INT.
- An NMI line held low after service. An edge detector that acts on level fires a second time.
- An `im_sel` of 3. A design that decodes this value changes the mode.
- A memory that stalls `rd_ready`. A design that drops or changes its request during the stall breaks the read ordering.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [1:0] {
    IM0 = 2'd0,
    IM1 = 2'd1,
    IM2 = 2'd2
  } im_mode_t;

  typedef enum logic [3:0] {
    S_IDLE,
    S_NPUSH,
    S_NJUMP,
    S_IACK,
    S_IPUSH,
    S_RDLO,
    S_WLO,
    S_RDHI,
    S_WHI,
    S_JUMP,
    S_INJ
  } seq_state_t;
endpackage

// File: rtl/irq_seq_enable.sv
module irq_seq_enable
  import irq_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ev_ei,
  input  logic     ev_di,
  input  logic     ev_retn,
  input  logic     ev_im,
  input  logic [1:0] im_sel,
  input  logic     take_nmi,
  input  logic     take_int,
  output logic     iff1,
  output logic     iff2,
  output im_mode_t mode
);
  // Priority: acceptance > DI > EI > RETN
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iff1 <= 1'b0;
      iff2 <= 1'b0;
    end else if (take_int) begin
      iff1 <= 1'b0;
      iff2 <= 1'b0;
    end else if (take_nmi) begin
      iff1 <= 1'b0;
    end else if (ev_di) begin
      iff1 <= 1'b0;
      iff2 <= 1'b0;
    end else if (ev_ei) begin
      iff1 <= 1'b1;
      iff2 <= 1'b1;
    end else if (ev_retn) begin
      iff1 <= iff2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= IM0;
    end else if (ev_im && (im_sel != 2'd3)) begin
      mode <= im_mode_t'(im_sel);
    end
  end
endmodule

// File: rtl/irq_seq_nmi.sv
module irq_seq_nmi (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_n,
  input  logic take_nmi,
  output logic nmi_pend
);
  logic nmi_prev;
  logic fall;

  assign fall = nmi_prev && !nmi_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_prev <= 1'b1;
      nmi_pend <= 1'b0;
    end else begin
      nmi_prev <= nmi_n;
      if (fall)          nmi_pend <= 1'b1;
      else if (take_nmi) nmi_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_seq_vector.sv
module irq_seq_vector
  import irq_seq_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 16,
  parameter logic [AW-1:0] NMI_VEC = 16'h0066,
  parameter logic [AW-1:0] IM1_VEC = 16'h0038
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_ack,
  input  logic          cap_lo,
  input  logic          cap_hi,
  input  logic          sel_hi,
  input  logic          is_nmi,
  input  im_mode_t      mode,
  input  logic [DW-1:0] dbus,
  input  logic [DW-1:0] i_reg,
  input  logic [DW-1:0] rsp_data,
  output logic [AW-1:0] rd_addr,
  output logic [AW-1:0] pc_new,
  output logic [DW-1:0] inj_op
);
  localparam int HW = AW - DW;

  logic [DW-1:0] vec_q, ipage_q, lo_q, hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q   <= '0;
      ipage_q <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
    end else begin
      if (cap_ack) begin
        vec_q   <= dbus;
        ipage_q <= i_reg;
      end
      if (cap_lo) lo_q <= rsp_data;
      if (cap_hi) hi_q <= rsp_data;
    end
  end

  // Even vector: bit 0 replaced by the byte select
  assign rd_addr = {ipage_q[HW-1:0], vec_q[DW-1:1], sel_hi};
  assign inj_op  = vec_q;

  always_comb begin
    if (is_nmi)          pc_new = NMI_VEC;
    else if (mode == IM1) pc_new = IM1_VEC;
    else                  pc_new = {hi_q[HW-1:0], lo_q};
  end
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_seq_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 16,
  parameter logic [AW-1:0] NMI_VEC = 16'h0066,
  parameter logic [AW-1:0] IM1_VEC = 16'h0038
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          int_n,
  input  logic          nmi_n,
  input  logic          instr_done,
  input  logic          ev_ei,
  input  logic          ev_di,
  input  logic          ev_retn,
  input  logic          ev_im,
  input  logic [1:0]    im_sel,
  input  logic [DW-1:0] i_reg,
  input  logic [DW-1:0] dbus,
  output logic          iack,
  output logic          push_pc,
  output logic          pc_load,
  output logic [AW-1:0] pc_new,
  output logic          inj_valid,
  output logic [DW-1:0] inj_op,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [AW-1:0] rd_addr,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  output logic          busy
);
  seq_state_t st, st_nx;
  logic       iff1, iff2, nmi_pend;
  im_mode_t   mode;
  logic       boundary, take_nmi, take_int;

  assign boundary = (st == S_IDLE) && instr_done && !ev_ei && !ev_di;
  assign take_nmi = boundary && nmi_pend;
  assign take_int = boundary && !nmi_pend && !int_n && iff1;

  irq_seq_enable u_enable (
    .clk(clk), .rst_n(rst_n),
    .ev_ei(ev_ei), .ev_di(ev_di), .ev_retn(ev_retn),
    .ev_im(ev_im), .im_sel(im_sel),
    .take_nmi(take_nmi), .take_int(take_int),
    .iff1(iff1), .iff2(iff2), .mode(mode)
  );

  irq_seq_nmi u_nmi (
    .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n),
    .take_nmi(take_nmi), .nmi_pend(nmi_pend)
  );

  irq_seq_vector #(
    .DW(DW), .AW(AW), .NMI_VEC(NMI_VEC), .IM1_VEC(IM1_VEC)
  ) u_vector (
    .clk(clk), .rst_n(rst_n),
    .cap_ack(st == S_IACK),
    .cap_lo(st == S_WLO && rsp_valid),
    .cap_hi(st == S_WHI && rsp_valid),
    .sel_hi(st == S_RDHI),
    .is_nmi(st == S_NJUMP),
    .mode(mode),
    .dbus(dbus), .i_reg(i_reg), .rsp_data(rsp_data),
    .rd_addr(rd_addr), .pc_new(pc_new), .inj_op(inj_op)
  );

  always_comb begin
    st_nx = st;
    unique case (st)
      S_IDLE:  if (take_nmi) st_nx = S_NPUSH;
               else if (take_int) st_nx = S_IACK;
      S_NPUSH: st_nx = S_NJUMP;
      S_IACK:  st_nx = (mode == IM0) ? S_INJ : S_IPUSH;
      S_IPUSH: st_nx = (mode == IM2) ? S_RDLO : S_JUMP;
      S_RDLO:  if (rd_ready) st_nx = S_WLO;
      S_WLO:   if (rsp_valid) st_nx = S_RDHI;
      S_RDHI:  if (rd_ready) st_nx = S_WHI;
      S_WHI:   if (rsp_valid) st_nx = S_JUMP;
      S_NJUMP, S_JUMP, S_INJ: st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= S_IDLE;
    else        st <= st_nx;
  end

  assign iack      = (st == S_IACK);
  assign push_pc   = (st == S_NPUSH) || (st == S_IPUSH);
  assign pc_load   = (st == S_NJUMP) || (st == S_JUMP);
  assign inj_valid = (st == S_INJ);
  assign rd_valid  = (st == S_RDLO) || (st == S_RDHI);
  assign busy      = (st != S_IDLE);
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
  parameter int AW = 16,
  parameter logic [AW-1:0] NMI_VEC = 16'h0066
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ev_ei,
  input logic          ev_di,
  input logic          ev_retn,
  input logic          int_n,
  input logic          iff1,
  input logic          iff2,
  input logic          take_nmi,
  input logic          take_int,
  input logic          iack,
  input logic          push_pc,
  input logic          pc_load,
  input logic          inj_valid,
  input logic [AW-1:0] pc_new,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [AW-1:0] rd_addr
);
  a_r2_ei_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ei && !ev_di) |=> (iff1 && iff2));

  a_r2_di_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ev_di |=> (!iff1 && !iff2));

  a_r2_int_needs_iff: assert property (@(posedge clk) disable iff (!rst_n)
    take_int |-> (iff1 && !int_n));

  a_r5_retn_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_retn && !ev_ei && !ev_di && !take_nmi && !take_int) |=> (iff1 == $past(iff2)));

  a_r4_nmi_keeps_iff2: assert property (@(posedge clk) disable iff (!rst_n)
    (take_nmi && !ev_retn) |=> (!iff1 && iff2 == $past(iff2)));

  a_r4_nmi_push: assert property (@(posedge clk) disable iff (!rst_n)
    take_nmi |=> push_pc);

  a_r4_nmi_jump: assert property (@(posedge clk) disable iff (!rst_n)
    $past(take_nmi) |=> (pc_load && pc_new == NMI_VEC));

  a_r6_int_clears: assert property (@(posedge clk) disable iff (!rst_n)
    take_int |=> (!iff1 && !iff2 && iack));

  a_r6_iack_single: assert property (@(posedge clk) disable iff (!rst_n)
    iack |=> (!iack && (push_pc || inj_valid)));

  a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));
endmodule

bind irq_seq irq_seq_chk #(.AW(AW), .NMI_VEC(NMI_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .ev_ei(ev_ei), .ev_di(ev_di), .ev_retn(ev_retn), .int_n(int_n),
  .iff1(iff1), .iff2(iff2),
  .take_nmi(take_nmi), .take_int(take_int),
  .iack(iack), .push_pc(push_pc), .pc_load(pc_load),
  .inj_valid(inj_valid), .pc_new(pc_new),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr)
);

// File: tb/irq_seq_bench.sv
module irq_seq_bench;
  localparam int K_ACK = 0, K_PUSH = 1, K_JUMP = 2, K_INJ = 3, K_RD = 4;

  typedef struct {
    int          kind;
    logic [15:0] val;
    string       req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic int_n = 1'b1, nmi_n = 1'b1, instr_done = 1'b0;
  logic ev_ei = 1'b0, ev_di = 1'b0, ev_retn = 1'b0, ev_im = 1'b0;
  logic [1:0] im_sel = 2'd0;
  logic [7:0] i_reg = 8'h00, dbus = 8'h00;
  logic iack, push_pc, pc_load, inj_valid, rd_valid, busy;
  logic [15:0] pc_new, rd_addr;
  logic [7:0] inj_op;
  logic rd_ready = 1'b0, rsp_valid = 1'b0;
  logic [7:0] rsp_data = 8'h00;

  int errors = 0, checks = 0;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  irq_seq u_irq_seq (
    .clk(clk), .rst_n(rst_n), .int_n(int_n), .nmi_n(nmi_n),
    .instr_done(instr_done), .ev_ei(ev_ei), .ev_di(ev_di),
    .ev_retn(ev_retn), .ev_im(ev_im), .im_sel(im_sel),
    .i_reg(i_reg), .dbus(dbus), .iack(iack), .push_pc(push_pc),
    .pc_load(pc_load), .pc_new(pc_new), .inj_valid(inj_valid),
    .inj_op(inj_op), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .busy(busy)
  );

  function automatic logic [7:0] tbl(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_ev(input int kind, input logic [15:0] val, input string req);
    exp_t e;
    e.kind = kind; e.val = val; e.req = req;
    sb.push_back(e);
  endtask

  // Table memory: one stall cycle on each request, data the cycle after handshake
  logic seen = 1'b0, hs = 1'b0;
  logic [15:0] hs_addr = 16'h0;
  always @(negedge clk) begin
    seen    <= rd_valid && !rd_ready;
    hs      <= rd_valid && rd_ready;
    hs_addr <= rd_addr;
  end
  always @(posedge clk) begin
    #1;
    rd_ready  <= seen;
    rsp_valid <= hs;
    rsp_data  <= tbl(hs_addr);
  end

  // Monitor: compares every observed event with the scoreboard head
  task automatic observe(input int kind, input logic [15:0] val);
    exp_t e;
    if (sb.size() == 0) begin
      check(1'b0, "unexpected event", 16'(kind), 16'hFFFF);
    end else begin
      e = sb.pop_front();
      check(e.kind == kind && e.val == val, e.req, {12'(kind), val[3:0]} ^ 16'h0 | val,
            e.val);
      if (e.kind != kind)
        $display("  kind actual=%0d expected=%0d", kind, e.kind);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (iack)                observe(K_ACK, 16'h0);
      if (push_pc)             observe(K_PUSH, 16'h0);
      if (pc_load)             observe(K_JUMP, pc_new);
      if (inj_valid)           observe(K_INJ, {8'h00, inj_op});
      if (rd_valid && rd_ready) observe(K_RD, rd_addr);
    end
  end

  task automatic boundary(input bit ei, input bit di, input bit retn,
                          input bit im, input logic [1:0] sel);
    @(posedge clk); #1;
    instr_done = 1'b1; ev_ei = ei; ev_di = di; ev_retn = retn;
    ev_im = im; im_sel = sel;
    @(posedge clk); #1;
    instr_done = 1'b0; ev_ei = 1'b0; ev_di = 1'b0; ev_retn = 1'b0; ev_im = 1'b0;
  endtask

  task automatic settle();
    repeat (14) @(posedge clk);
    check(sb.size() == 0, "sequence complete", 16'(sb.size()), 16'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs idle during reset
    check(!iack && !push_pc && !pc_load && !inj_valid && !rd_valid && !busy,
          "R1 reset outputs", {10'h0, iack, push_pc, pc_load, inj_valid, rd_valid, busy}, 16'h0);
    @(posedge clk); #1; rst_n = 1'b1;

    // R1/R2: INT while flags are clear after reset is ignored
    dbus = 8'hE7; int_n = 1'b0;
    boundary(0, 0, 0, 0, 2'd0);
    boundary(0, 0, 0, 0, 2'd0);
    settle();

    // R3/R7: EI boundary blocks; next boundary takes INT in reset mode 0
    boundary(1, 0, 0, 0, 2'd0);
    repeat (3) @(posedge clk);
    check(!busy, "R3 no acceptance on EI boundary", {15'h0, busy}, 16'h0);
    expect_ev(K_ACK, 16'h0, "R6 ack mode0");
    expect_ev(K_INJ, 16'h00E7, "R7 injected opcode");
    boundary(0, 0, 0, 0, 2'd0);
    settle();
    // R6: flags now clear, INT still low, ignored
    boundary(0, 0, 0, 0, 2'd0);
    settle();

    // R8/R11: mode 1
    boundary(0, 0, 0, 1, 2'd1);
    boundary(1, 0, 0, 0, 2'd0);
    expect_ev(K_ACK, 16'h0, "R6 ack mode1");
    expect_ev(K_PUSH, 16'h0, "R8 push");
    expect_ev(K_JUMP, 16'h0038, "R8 fixed entry");
    boundary(0, 0, 0, 0, 2'd0);
    settle();

    // R9/R10/R11: mode 2, odd vector, then im_sel=3 keeps mode 2
    boundary(0, 0, 0, 1, 2'd2);
    boundary(0, 0, 0, 1, 2'd3);
    i_reg = 8'h13; dbus = 8'h17;
    boundary(1, 0, 0, 0, 2'd0);
    expect_ev(K_ACK, 16'h0, "R6 ack mode2");
    expect_ev(K_PUSH, 16'h0, "R9 push");
    expect_ev(K_RD, 16'h1316, "R9 low-byte address even");
    expect_ev(K_RD, 16'h1317, "R9 high-byte address");
    expect_ev(K_JUMP, {tbl(16'h1317), tbl(16'h1316)}, "R9 table entry");
    boundary(0, 0, 0, 0, 2'd0);
    settle();

    // R4/R5: NMI beats pending INT; INT waits until RETN restores flag 1
    boundary(1, 0, 0, 0, 2'd0);
    @(posedge clk); #1; nmi_n = 1'b0;
    expect_ev(K_PUSH, 16'h0, "R4 nmi push first");
    expect_ev(K_JUMP, 16'h0066, "R4 nmi entry");
    boundary(0, 0, 0, 0, 2'd0);
    settle();
    boundary(0, 0, 0, 0, 2'd0);
    settle();
    i_reg = 8'h20; dbus = 8'h40;
    expect_ev(K_ACK, 16'h0, "R5 int after retn");
    expect_ev(K_PUSH, 16'h0, "R5 push");
    expect_ev(K_RD, 16'h2040, "R5 low read");
    expect_ev(K_RD, 16'h2041, "R5 high read");
    expect_ev(K_JUMP, {tbl(16'h2041), tbl(16'h2040)}, "R5 entry");
    boundary(0, 0, 1, 0, 2'd0);
    boundary(0, 0, 0, 0, 2'd0);
    settle();

    // R2/R4: DI blocks INT, yet a new NMI edge is still taken
    boundary(1, 0, 0, 0, 2'd0);
    boundary(0, 1, 0, 0, 2'd0);
    boundary(0, 0, 0, 0, 2'd0);
    settle();
    @(posedge clk); #1; nmi_n = 1'b1;
    @(posedge clk); #1; nmi_n = 1'b0;
    expect_ev(K_PUSH, 16'h0, "R4 nmi with flags clear");
    expect_ev(K_JUMP, 16'h0066, "R4 nmi entry again");
    boundary(0, 0, 0, 0, 2'd0);
    settle();
    // R4: line still low, no retrigger
    boundary(0, 0, 0, 0, 2'd0);
    settle();

    check(sb.size() == 0, "final scoreboard empty", 16'(sb.size()), 16'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule